// File: doc/BRIEF.md
# Display Word Buffer and Pixel Serializer

This block sits between a microcoded task that fetches display words and the serial pixel output of a raster display. The task writes 16-bit words into a 16-entry circular buffer. A serializer unloads one word every sixteen pixel times and shifts it out most significant bit first. A decode of the write and read pointer pair drives two flags. One says the buffer is empty. The other, a stop-wake flag, tells the word task to stop asking for service once the buffer is nearly full. The block has no full flag.

A two-bit mode register selects half-rate pixel clocking and inverse video. The CPU loads these two bits from the top two bits of its mode word. At the end of every scanline, a strobe qualified by the display clock enable clears both pointers. A blanking input forces the pixel output low.

The serializer is a two-phase state machine. In state `PH_EMIT` a pixel is being shown for its first (or only) clock. In state `PH_HOLD` a half-rate pixel is repeated for a second clock. The transitions are as follows:
- `PH_EMIT` goes to `PH_HOLD` on an enabled clock in half-rate mode, and stays in `PH_EMIT` otherwise.
- `PH_HOLD` goes to `PH_EMIT` on any enabled clock, and stays in `PH_HOLD` while the pixel enable is low.

The shift register advances on an enabled clock in full-rate mode, or on an enabled clock in `PH_HOLD`. Reset leaves the machine in `PH_HOLD`, so the first enabled clock loads a word in either mode.

Top module: `scan_word_buffer`

## Requirements
- R1: After reset `empty` is 1, `stop_wake` is 0 and `pix_out` is 0.
- R2: Words written with `wr_en` are unloaded and shown in the order they were written.
- R3: `empty` is 1 exactly when the read and write pointers are equal. An unload from an empty buffer shows sixteen zero pixels and leaves the read pointer unchanged.
- R4: `stop_wake` is 1 when the write pointer is 12 or more entries ahead of the read pointer, modulo 16, and 0 otherwise.
- R5: A clock with `line_end` and `dclk_en` both 1 resets both pointers, so that `empty` is 1 and `stop_wake` is 0 on the next clock. This clear overrides a write or unload in the same clock. `line_end` with `dclk_en` 0 has no effect.
- R6: `mode_we` loads `mode_bits`. Bit 1 (the mode word's bit 15) selects half-rate pixels, and bit 0 (the mode word's bit 14) selects inverse video. Reset clears both.
- R7: With inverse video on, each word is XORed with 16'hFFFF when it is loaded into the shifter.
- R8: In full-rate mode each clock with `shift_en` 1 shows one pixel, most significant bit first, and a new word is loaded every 16 such clocks. After reset, the first enabled clock loads the first word, and its bit 15 appears on `pix_out` after that edge.
- R9: In half-rate mode each pixel is shown for two enabled clocks, so one word lasts 32 enabled clocks.
- R10: While `blank` is 1, `pix_out` is 0 in the same cycle.
- R11: A write and an unload in the same clock both take effect.
- R12: While `shift_en` is 0 the shifter, its bit position and its phase hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pixel time per enabled cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe from the word task |
| wr_data | input | 16 | Display word to store |
| mode_we | input | 1 | Load strobe for the mode bits |
| mode_bits | input | 2 | [1] half-rate pixels, [0] inverse video |
| line_end | input | 1 | Scanline-end strobe |
| dclk_en | input | 1 | Display clock qualifier for the clear |
| blank | input | 1 | Blanking; forces the pixel output low |
| shift_en | input | 1 | Pixel clock enable for the serializer |
| pix_out | output | 1 | Serial pixel stream |
| empty | output | 1 | Buffer holds no words |
| stop_wake | output | 1 | Word task must stop requesting service |

## Verification
The assertions check on every cycle that a clear empties the buffer, that a write which is neither cleared nor matched by an unload leaves the buffer non-empty, and that the flags hold in an idle cycle. They also check that the serializer freezes while its enable is low, and that half-rate mode holds each pixel for two clocks. Only the bench scenarios can show the pixel stream itself: bit order, inversion, word-to-word continuity with a write landing on an unload edge, the exact stop-wake threshold, the gated clear, and that an unload from an empty buffer does not disturb the pointers.

// File: rtl/scan_buf_pkg.sv
package scan_buf_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned BUF_DEPTH  = 16;
    localparam int unsigned STOP_LEVEL = 12;

    typedef enum logic {
        PH_EMIT = 1'b0,
        PH_HOLD = 1'b1
    } pix_phase_t;

endpackage

// File: rtl/sb_mode_reg.sv
module sb_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [1:0] mode_bits,
    output logic       half_rate,
    output logic       inverse
);

    logic [1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
        end else if (mode_we) begin
            mode_q <= mode_bits;
        end
    end

    assign half_rate = mode_q[1];
    assign inverse   = mode_q[0];

endmodule

// File: rtl/sb_word_store.sv
module sb_word_store #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned STOP  = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    input  logic         clr,
    output logic [W-1:0] rd_data,
    output logic         rd_ok,
    output logic         empty,
    output logic         stop_wake
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [0:DEPTH-1];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] level;
    logic             wr_ok;

    // Pointer-pair decode: distance from reader to writer, modulo depth
    assign level     = wr_ptr - rd_ptr;
    assign empty     = (level == '0);
    assign stop_wake = (level >= PTR_W'(STOP));

    assign wr_ok   = wr_en & ~clr;
    assign rd_ok   = rd_req & ~empty & ~clr;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + PTR_W'(1);
            if (rd_ok) rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    // R5: a clear leaves an empty buffer and a released writer
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !stop_wake));

    // R2: a stored word that nothing removes keeps the buffer non-empty
    a_r2_write_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && !rd_req) |=> !empty);

    // R3: with no write, unload or clear the flags hold
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_req && !clr) |=> ($stable(empty) && $stable(stop_wake)));

endmodule

// File: rtl/sb_pix_shift.sv
module sb_pix_shift
    import scan_buf_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         half_rate,
    input  logic         inverse,
    input  logic         blank,
    input  logic [W-1:0] rd_data,
    input  logic         rd_ok,
    output logic         rd_req,
    output logic         pix_out
);

    localparam int unsigned CNT_W = $clog2(W);

    pix_phase_t       phase, phase_n;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             step;
    logic             last_bit;

    // Next-phase logic
    always_comb begin
        phase_n = phase;
        unique case (phase)
            PH_EMIT: phase_n = (shift_en && half_rate) ? PH_HOLD : PH_EMIT;
            PH_HOLD: phase_n = shift_en ? PH_EMIT : PH_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_HOLD;
        else        phase <= phase_n;
    end

    assign step     = shift_en && (!half_rate || phase == PH_HOLD);
    assign last_bit = (bit_cnt == CNT_W'(W - 1));
    assign rd_req   = step && last_bit;

    // Output process: shifter and bit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= CNT_W'(W - 1);
        end else if (step) begin
            if (last_bit) begin
                shreg   <= rd_ok ? (rd_data ^ {W{inverse}}) : '0;
                bit_cnt <= '0;
            end else begin
                shreg   <= {shreg[W-2:0], 1'b0};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end

    assign pix_out = shreg[W-1] & ~blank;

    // R12: no pixel enable, no movement
    a_r12_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(shreg) && $stable(bit_cnt) && $stable(phase)));

    // R9: the first half of a half-rate pixel does not move the shifter
    a_r9_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && half_rate && phase == PH_EMIT) |=> $stable(shreg));

    // R8: full-rate operation never rests in the hold phase
    a_r8_full_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !half_rate) |=> (phase == PH_EMIT));

endmodule

// File: rtl/scan_word_buffer.sv
module scan_word_buffer
    import scan_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mode_we,
    input  logic [1:0]        mode_bits,
    input  logic              line_end,
    input  logic              dclk_en,
    input  logic              blank,
    input  logic              shift_en,
    output logic              pix_out,
    output logic              empty,
    output logic              stop_wake
);

    logic              half_rate;
    logic              inverse;
    logic              buf_clr;
    logic              rd_req;
    logic              rd_ok;
    logic [WORD_W-1:0] rd_data;

    assign buf_clr = line_end & dclk_en;

    sb_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_bits (mode_bits),
        .half_rate (half_rate),
        .inverse   (inverse)
    );

    sb_word_store #(
        .W     (WORD_W),
        .DEPTH (BUF_DEPTH),
        .STOP  (STOP_LEVEL)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .clr       (buf_clr),
        .rd_data   (rd_data),
        .rd_ok     (rd_ok),
        .empty     (empty),
        .stop_wake (stop_wake)
    );

    sb_pix_shift #(
        .W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .half_rate (half_rate),
        .inverse   (inverse),
        .blank     (blank),
        .rd_data   (rd_data),
        .rd_ok     (rd_ok),
        .rd_req    (rd_req),
        .pix_out   (pix_out)
    );

endmodule

// File: tb/scan_word_buffer_tb_top.sv
module scan_word_buffer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, mode_we, line_end, dclk_en, blank, shift_en;
    logic [15:0] wr_data;
    logic [1:0]  mode_bits;
    logic        pix_out, empty, stop_wake;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    scan_word_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_we(mode_we), .mode_bits(mode_bits), .line_end(line_end),
        .dclk_en(dclk_en), .blank(blank), .shift_en(shift_en),
        .pix_out(pix_out), .empty(empty), .stop_wake(stop_wake)
    );

    // {half, inverse, written word, expected shown word}
    localparam logic [33:0] VEC [6] = '{
        {1'b0, 1'b0, 16'hA5C3, 16'hA5C3},
        {1'b0, 1'b1, 16'h8001, 16'h7FFE},
        {1'b1, 1'b0, 16'h1234, 16'h1234},
        {1'b1, 1'b1, 16'hF00F, 16'h0FF0},
        {1'b0, 1'b0, 16'hFFFF, 16'hFFFF},
        {1'b0, 1'b1, 16'h0000, 16'hFFFF}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 0; mode_we = 0; line_end = 0; dclk_en = 0;
        blank = 0; shift_en = 0; wr_data = '0; mode_bits = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [15:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic h, input logic i);
        mode_we = 1'b1; mode_bits = {h, i};
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 empty", {15'b0, empty}, 16'd1);
        check("R1 stop_wake", {15'b0, stop_wake}, 16'd0);
        check("R1 pix_out", {15'b0, pix_out}, 16'd0);

        // R6 R7 R8 R9: one word per table row, each mode combination
        for (int r = 0; r < 6; r++) begin
            logic       h;
            logic [15:0] e;
            int         rep;
            h   = VEC[r][33];
            e   = VEC[r][15:0];
            rep = h ? 2 : 1;
            do_reset();
            set_mode(VEC[r][33], VEC[r][32]);
            push(VEC[r][31:16]);
            check("R12 idle pixel", {15'b0, pix_out}, 16'd0);
            shift_en = 1'b1;
            for (int t = 1; t <= 16 * rep; t++) begin
                @(negedge clk);
                check(h ? "R9 half-rate pixel" : (VEC[r][32] ? "R7 inverse pixel" : "R8 pixel"),
                      {15'b0, pix_out}, {15'b0, e[15 - (t - 1) / rep]});
            end
            shift_en = 1'b0;
            check("R6 word consumed", {15'b0, empty}, 16'd1);
        end

        // R4: stop-wake threshold at twelve words ahead
        do_reset();
        for (int k = 0; k < 11; k++) push(16'h0100 + 16'(k));
        check("R4 below threshold", {15'b0, stop_wake}, 16'd0);
        check("R3 not empty", {15'b0, empty}, 16'd0);
        push(16'h0200);
        check("R4 at threshold", {15'b0, stop_wake}, 16'd1);

        // R5: ungated strobe is ignored, gated clear wins over a write
        line_end = 1'b1; dclk_en = 1'b0;
        @(negedge clk);
        line_end = 1'b0;
        check("R5 ungated empty", {15'b0, empty}, 16'd0);
        check("R5 ungated stop", {15'b0, stop_wake}, 16'd1);
        line_end = 1'b1; dclk_en = 1'b1; wr_en = 1'b1; wr_data = 16'hDEAD;
        @(negedge clk);
        line_end = 1'b0; dclk_en = 1'b0; wr_en = 1'b0;
        check("R5 clear empty", {15'b0, empty}, 16'd1);
        check("R5 clear stop", {15'b0, stop_wake}, 16'd0);

        // R3: unload from an empty buffer shows zeros, pointer untouched
        shift_en = 1'b1;
        for (int t = 1; t <= 16; t++) begin
            @(negedge clk);
            check("R3 empty unload pixel", {15'b0, pix_out}, 16'd0);
        end
        shift_en = 1'b0;
        push(16'hC001);
        check("R3 no underflow", {15'b0, empty}, 16'd0);
        shift_en = 1'b1;
        for (int t = 1; t <= 16; t++) begin
            logic [15:0] e;
            e = 16'hC001;
            @(negedge clk);
            check("R2 word after empty", {15'b0, pix_out}, {15'b0, e[16 - t]});
            if (t == 1) begin
                blank = 1'b1; #1;
                check("R10 blanked pixel", {15'b0, pix_out}, 16'd0);
                blank = 1'b0; #1;
            end
        end
        shift_en = 1'b0;

        // R2 R11: continuous stream, write lands on an unload edge
        do_reset();
        push(16'h9C31);
        push(16'h5AF0);
        shift_en = 1'b1;
        for (int t = 1; t <= 48; t++) begin
            logic [47:0] s;
            s = {16'h9C31, 16'h5AF0, 16'h0E77};
            @(negedge clk);
            check(t > 32 ? "R11 word written on unload" : "R2 stream order",
                  {15'b0, pix_out}, {15'b0, s[48 - t]});
            if (t == 16) begin wr_en = 1'b1; wr_data = 16'h0E77; end
            if (t == 17) wr_en = 1'b0;
        end
        shift_en = 1'b0;
        check("R11 all consumed", {15'b0, empty}, 16'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule